// File: doc/BRIEF.md
# I/O Page-Table Translation Unit

This unit maps a 32-bit device-side virtual address onto a 36-bit physical address through a single-level table of 4 KB page entries kept in system memory. A requester offers an address and a write flag on a valid/ready channel. The unit works out where that page's entry lives, issues one 32-bit read on its memory port, judges the entry, and returns the physical address with a permission code, or a fault.

The entry address depends on two configuration inputs. `cfg_base` is a table base register, shifted left by four bits. `cfg_range` selects the size of the translation window as 16 MB shifted left by the code. Address bits above the window are discarded before the page index is formed. Each page owns one 4-byte slot in the table.

A fault can come from an invalid entry, or from a write to an entry without write permission. On a fault the unit loads a fault status word and a fault address for a neighbouring register bank, and it raises a one-cycle interrupt pulse. Only one translation is in flight at a time.

The controller has four states:
- `ST_IDLE` waits for a request. On accept it takes the `accept` transition to `ST_FETCH`.
- `ST_FETCH` holds the memory read request. When the read is taken it follows `issued` to `ST_WAIT`.
- `ST_WAIT` waits for the entry word. When the word arrives it follows `judged` to `ST_DONE`.
- `ST_DONE` holds the response. When the response is taken it follows `retire` back to `ST_IDLE`.

Top module: `iopt_xlate`

## Requirements
- R1: `req_ready` is high only in `ST_IDLE`. While a translation is being fetched, judged or held for return, no new request is accepted and no extra memory read is issued.
- R2: The entry address is computed as follows. Let W = 24 + `cfg_range`. Take the request address, keep only its bits [W-1:12], and shift that right by 10. Add the result to `{cfg_base, 4'b0000}`.
- R3: Each translation issues exactly one memory read. `mem_req_valid` and `mem_req_addr` are held steady until `mem_req_ready` is seen.
- R4: The entry word is taken big-endian: `mem_rsp_data[31:24]` is the byte at the lowest address. Bits [31:8] are the physical frame, bit 2 grants write and bit 1 marks the entry valid. Bits 7 and 0 have no effect on any output.
- R5: On success, `rsp_pa` equals `{entry[31:8], req_addr[11:0]}`.
- R6: `rsp_perm` encodes permission: 2'b11 is read-write (bit 2 set), 2'b01 is read-only (bit 2 clear) and 2'b00 is none.
- R7: An entry with bit 1 clear faults, for both reads and writes.
- R8: A write to an entry with bit 2 clear faults. A read of the same entry succeeds as read-only.
- R9: A faulted response has `rsp_fault` = 1, `rsp_perm` = 2'b00 and `rsp_pa` = 0.
- R10: A fault loads `flt_status` with 32'hC082_0000 for a write or 32'hC086_0000 for a read, and loads `flt_addr` with the request address with bits [11:0] cleared. A later fault overwrites both. A successful translation leaves both unchanged.
- R11: `irq` pulses high for exactly one cycle. The pulse falls in the first cycle of a faulted response, the same cycle in which the new fault registers appear.
- R12: After reset, `flt_status` = 32'h0080_0000, `flt_addr` = 0, `req_ready` = 1, and `rsp_valid`, `mem_req_valid` and `irq` are 0.
- R13: While `rsp_valid` is high and `rsp_ready` is low, `rsp_fault`, `rsp_perm` and `rsp_pa` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 32 | Table base register value |
| cfg_range | input | 3 | Window size code |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Unit can take a request |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 36 | Entry address |
| mem_rsp_valid | input | 1 | Entry word returned |
| mem_rsp_data | input | 32 | Entry word |
| rsp_valid | output | 1 | Translation result held |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_fault | output | 1 | Translation faulted |
| rsp_pa | output | 36 | Physical address |
| rsp_perm | output | 2 | Permission code |
| flt_status | output | 32 | Fault status word |
| flt_addr | output | 32 | Faulting page address |
| irq | output | 1 | Fault interrupt pulse |

## Verification
The assertions check the following on every cycle:
- that only one translation is in flight;
- that the memory request and the response are held while stalled;
- that a faulted response carries no permission and a zero address;
- that the interrupt lasts a single cycle and coincides with a correctly formed status word.

The bench's scenarios are needed for the rest:
- the arithmetic of the entry address across window sizes;
- the frame/offset splice;
- the read-versus-write permission outcomes;
- the read flag in the status;
- the overwrite of earlier fault data.

// File: rtl/iopt_pkg.sv
package iopt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } iopt_state_e;

    typedef enum logic [1:0] {
        PERM_NONE = 2'b00,
        PERM_RO   = 2'b01,
        PERM_RW   = 2'b11
    } iopt_perm_e;

    // entry flag positions
    localparam int ENT_WR_BIT  = 2;
    localparam int ENT_VLD_BIT = 1;

    // fault status encoding
    localparam logic [31:0] FLT_WORD_BASE = 32'hC082_0000;
    localparam int          FLT_RD_BIT    = 18;
    localparam logic [31:0] FLT_WORD_RST  = 32'h0080_0000;

endpackage

// File: rtl/iopt_walk_addr.sv
module iopt_walk_addr #(
    parameter int VA_W         = 32,
    parameter int PA_W         = 36,
    parameter int PAGE_SHIFT   = 12,
    parameter int RANGE_W      = 3,
    parameter int MIN_WIN_LOG2 = 24
) (
    input  logic [VA_W-1:0]    va,
    input  logic [VA_W-1:0]    base,
    input  logic [RANGE_W-1:0] range_sel,
    output logic [PA_W-1:0]    ent_addr
);
    localparam int BASE_SHIFT = PA_W - VA_W;
    localparam int IDX_SHIFT  = PAGE_SHIFT - 2;

    logic [VA_W-1:0] page_off;
    logic            unused_low;

    assign unused_low = ^va[PAGE_SHIFT-1:0];

    for (genvar g = 0; g < VA_W; g++) begin : g_off
        if (g < PAGE_SHIFT) begin : g_lo
            assign page_off[g] = 1'b0;
        end else begin : g_hi
            assign page_off[g] = va[g] &
                (32'(g) < (32'(MIN_WIN_LOG2) + 32'(range_sel)));
        end
    end

    assign ent_addr = {base, {BASE_SHIFT{1'b0}}} + PA_W'(page_off >> IDX_SHIFT);

endmodule

// File: rtl/iopt_pte_eval.sv
module iopt_pte_eval
    import iopt_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PA_W       = 36,
    parameter int ENT_W      = 32,
    parameter int PAGE_SHIFT = 12
) (
    input  logic [ENT_W-1:0] pte,
    input  logic [VA_W-1:0]  va,
    input  logic             is_write,
    output logic             fault,
    output logic [PA_W-1:0]  pa,
    output iopt_perm_e       perm,
    output logic [31:0]      status,
    output logic [VA_W-1:0]  fault_addr
);
    localparam int FRAME_W = PA_W - PAGE_SHIFT;

    logic entry_ok, entry_wr, unused_bits;

    assign unused_bits = ^{pte[ENT_W-FRAME_W-1:ENT_WR_BIT+1], pte[0]};
    assign entry_ok    = pte[ENT_VLD_BIT];
    assign entry_wr    = pte[ENT_WR_BIT];

    always_comb begin
        fault      = !entry_ok || (is_write && !entry_wr);
        pa         = {pte[ENT_W-1:ENT_W-FRAME_W], va[PAGE_SHIFT-1:0]};
        perm       = entry_wr ? PERM_RW : PERM_RO;
        status     = FLT_WORD_BASE;
        status[FLT_RD_BIT] = !is_write;
        fault_addr = {va[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    end

endmodule

// File: rtl/iopt_ctrl.sv
module iopt_ctrl
    import iopt_pkg::*;
#(
    parameter int VA_W = 32,
    parameter int PA_W = 36
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_addr,
    input  logic            req_write,
    input  logic [PA_W-1:0] ent_addr_in,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [PA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic            ev_fault,
    input  logic [PA_W-1:0] ev_pa,
    input  iopt_perm_e      ev_perm,
    input  logic [31:0]     ev_status,
    input  logic [VA_W-1:0] ev_faddr,
    output logic [VA_W-1:0] va_q,
    output logic            wr_q,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic            rsp_fault,
    output logic [PA_W-1:0] rsp_pa,
    output logic [1:0]      rsp_perm,
    output logic [31:0]     flt_status,
    output logic [VA_W-1:0] flt_addr,
    output logic            irq
);
    iopt_state_e st, st_nxt;
    logic [PA_W-1:0] eaddr_q, pa_q;
    iopt_perm_e      perm_q;
    logic            fault_q, irq_q;
    logic [31:0]     fstat_q;
    logic [VA_W-1:0] faddr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:  if (req_valid)     st_nxt = ST_FETCH;
            ST_FETCH: if (mem_req_ready) st_nxt = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) st_nxt = ST_DONE;
            ST_DONE:  if (rsp_ready)     st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q    <= '0;
            wr_q    <= 1'b0;
            eaddr_q <= '0;
            pa_q    <= '0;
            perm_q  <= PERM_NONE;
            fault_q <= 1'b0;
            fstat_q <= FLT_WORD_RST;
            faddr_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (st == ST_IDLE && req_valid) begin
                va_q    <= req_addr;
                wr_q    <= req_write;
                eaddr_q <= ent_addr_in;
            end
            if (st == ST_WAIT && mem_rsp_valid) begin
                fault_q <= ev_fault;
                pa_q    <= ev_fault ? '0 : ev_pa;
                perm_q  <= ev_fault ? PERM_NONE : ev_perm;
                if (ev_fault) begin
                    fstat_q <= ev_status;
                    faddr_q <= ev_faddr;
                    irq_q   <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        req_ready     = (st == ST_IDLE);
        mem_req_valid = (st == ST_FETCH);
        mem_req_addr  = eaddr_q;
        rsp_valid     = (st == ST_DONE);
        rsp_fault     = fault_q;
        rsp_pa        = pa_q;
        rsp_perm      = perm_q;
        flt_status    = fstat_q;
        flt_addr      = faddr_q;
        irq           = irq_q;
    end

endmodule

// File: rtl/iopt_xlate.sv
module iopt_xlate
    import iopt_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PA_W       = 36,
    parameter int ENT_W      = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int RANGE_W    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VA_W-1:0]    cfg_base,
    input  logic [RANGE_W-1:0] cfg_range,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_addr,
    input  logic               req_write,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENT_W-1:0]   mem_rsp_data,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic               rsp_fault,
    output logic [PA_W-1:0]    rsp_pa,
    output logic [1:0]         rsp_perm,
    output logic [31:0]        flt_status,
    output logic [VA_W-1:0]    flt_addr,
    output logic               irq
);
    logic [PA_W-1:0] ent_addr, ev_pa;
    logic [VA_W-1:0] va_q, ev_faddr;
    logic            wr_q, ev_fault;
    iopt_perm_e      ev_perm;
    logic [31:0]     ev_status;

    iopt_walk_addr #(
        .VA_W(VA_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT), .RANGE_W(RANGE_W),
        .MIN_WIN_LOG2(24)
    ) u_walk (
        .va(req_addr), .base(cfg_base), .range_sel(cfg_range), .ent_addr(ent_addr)
    );

    iopt_pte_eval #(
        .VA_W(VA_W), .PA_W(PA_W), .ENT_W(ENT_W), .PAGE_SHIFT(PAGE_SHIFT)
    ) u_eval (
        .pte(mem_rsp_data), .va(va_q), .is_write(wr_q), .fault(ev_fault),
        .pa(ev_pa), .perm(ev_perm), .status(ev_status), .fault_addr(ev_faddr)
    );

    iopt_ctrl #(.VA_W(VA_W), .PA_W(PA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .ent_addr_in(ent_addr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .ev_fault(ev_fault), .ev_pa(ev_pa), .ev_perm(ev_perm),
        .ev_status(ev_status), .ev_faddr(ev_faddr),
        .va_q(va_q), .wr_q(wr_q),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
        .rsp_pa(rsp_pa), .rsp_perm(rsp_perm),
        .flt_status(flt_status), .flt_addr(flt_addr), .irq(irq)
    );

endmodule

// File: rtl/iopt_xlate_chk.sv
module iopt_xlate_chk #(
    parameter int VA_W = 32,
    parameter int PA_W = 36
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic            rsp_fault,
    input logic [PA_W-1:0] rsp_pa,
    input logic [1:0]      rsp_perm,
    input logic [31:0]     flt_status,
    input logic [VA_W-1:0] flt_addr,
    input logic            irq
);
    assert_single_flight_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || mem_req_valid) |-> !req_ready);

    assert_memreq_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_ok_has_perm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_perm == 2'b11 || rsp_perm == 2'b01));

    assert_fault_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_perm == 2'b00 && rsp_pa == '0));

    assert_status_form_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((flt_status & 32'hFFFB_FFFF) == 32'hC082_0000 && flt_addr[11:0] == 12'h0));

    assert_irq_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_with_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rsp_valid && rsp_fault));

    assert_rsp_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) &&
                                       $stable(rsp_fault) && $stable(rsp_perm)));
endmodule

bind iopt_xlate iopt_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_pa(rsp_pa), .rsp_perm(rsp_perm),
    .flt_status(flt_status), .flt_addr(flt_addr), .irq(irq)
);

// File: tb/test_iopt_xlate.sv
`timescale 1ns/1ps
module test_iopt_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [2:0]  cfg_range = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready, mem_req_valid, rsp_valid, rsp_fault, irq;
    logic        mem_req_ready = 1'b1, rsp_ready = 1'b0;
    logic [35:0] mem_req_addr, rsp_pa;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic [1:0]  rsp_perm;
    logic [31:0] flt_status, flt_addr;

    int total = 0, bad = 0, cyc = 0, mreq_cnt = 0;
    logic [31:0] tb_pte = '0;
    logic [35:0] seen_eaddr = '0;
    logic        g_fault, g_irq, g_irq_after;
    logic [35:0] g_pa;
    logic [1:0]  g_perm;

    always #5 clk = ~clk;

    iopt_xlate i_iopt_xlate (.*);

    // memory model: one-cycle latency, returns tb_pte
    always @(posedge clk) begin
        mem_rsp_valid <= mem_req_valid && mem_req_ready;
        mem_rsp_data  <= tb_pte;
        if (mem_req_valid && mem_req_ready) begin
            seen_eaddr <= mem_req_addr;
            mreq_cnt   <= mreq_cnt + 1;
        end
    end

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [35:0] exp_eaddr(logic [31:0] base, logic [2:0] rng, logic [31:0] va);
        logic [31:0] off;
        off = va & ((32'h1 << (24 + rng)) - 32'h1) & 32'hFFFF_F000;
        return {base, 4'h0} + {4'h0, off >> 10};
    endfunction

    task automatic run_xlate(input logic [31:0] va, input logic wr, input logic [31:0] pte,
                             input logic [2:0] rng, input logic [31:0] base,
                             input int mem_stall, input int rsp_hold);
        int n0;
        logic [35:0] a0;
        @(negedge clk);
        cfg_base = base; cfg_range = rng; tb_pte = pte;
        mem_req_ready = (mem_stall == 0);
        req_addr = va; req_write = wr; req_valid = 1'b1;
        n0 = mreq_cnt;
        @(negedge clk);
        req_valid = 1'b0;
        a0 = mem_req_addr;
        for (int i = 0; i < mem_stall; i++) begin
            check("R3 mem_req_valid held", 64'(mem_req_valid), 64'd1);
            check("R3 mem_req_addr held", 64'(mem_req_addr), 64'(a0));
            @(negedge clk);
        end
        mem_req_ready = 1'b1;
        for (int i = 0; i < 20 && !rsp_valid; i++) @(negedge clk);
        check("R1 rsp_valid reached", 64'(rsp_valid), 64'd1);
        g_irq = irq; g_fault = rsp_fault; g_pa = rsp_pa; g_perm = rsp_perm;
        if (rsp_hold > 0) begin
            req_valid = 1'b1; req_addr = 32'h0055_5000;
        end
        for (int i = 0; i < rsp_hold; i++) begin
            @(negedge clk);
            check("R1 req_ready low while busy", 64'(req_ready), 64'd0);
            check("R13 rsp held", {27'h0, rsp_valid, rsp_fault, rsp_perm, rsp_pa},
                  {27'h0, 1'b1, g_fault, g_perm, g_pa});
            check("R11 irq single cycle", 64'(irq), 64'd0);
        end
        req_valid = 1'b0;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        g_irq_after = irq;
        check("R3 one memory read per translation", 64'(mreq_cnt - n0), 64'd1);
        check("R2 entry address", 64'(seen_eaddr), 64'(exp_eaddr(base, rng, va)));
        check("R1 idle after retire", 64'(req_ready), 64'd1);
    endtask

    task automatic t_reset();
        check("R12 req_ready", 64'(req_ready), 64'd1);
        check("R12 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R12 mem_req_valid", 64'(mem_req_valid), 64'd0);
        check("R12 irq", 64'(irq), 64'd0);
        check("R12 flt_status", 64'(flt_status), 64'h0080_0000);
        check("R12 flt_addr", 64'(flt_addr), 64'd0);
    endtask

    task automatic t_read_rw();
        // bits 7 and 0 set to show they are ignored (R4)
        run_xlate(32'hFF12_3ABC, 1'b0, 32'hABCD_EF87, 3'd0, 32'h0001_2340, 0, 0);
        check("R4 R7 no fault", 64'(g_fault), 64'd0);
        check("R5 pa splice", 64'(g_pa), 64'h0_000A_BCDE_FABC);
        check("R6 perm rw", 64'(g_perm), 64'd3);
        check("R11 no irq on success", 64'(g_irq), 64'd0);
        check("R10 status untouched", 64'(flt_status), 64'h0080_0000);
    endtask

    task automatic t_write_ro();
        run_xlate(32'h0123_4567, 1'b1, 32'h1234_5602, 3'd1, 32'h0000_8000, 0, 0);
        check("R8 write to ro faults", 64'(g_fault), 64'd1);
        check("R9 pa zero", 64'(g_pa), 64'd0);
        check("R9 perm none", 64'(g_perm), 64'd0);
        check("R11 irq on fault", 64'(g_irq), 64'd1);
        check("R11 irq falls", 64'(g_irq_after), 64'd0);
        check("R10 write status", 64'(flt_status), 64'hC082_0000);
        check("R10 fault addr", 64'(flt_addr), 64'h0123_4000);
    endtask

    task automatic t_read_ro();
        run_xlate(32'h0123_4567, 1'b0, 32'h1234_5602, 3'd1, 32'h0000_8000, 0, 0);
        check("R8 read of ro ok", 64'(g_fault), 64'd0);
        check("R6 perm ro", 64'(g_perm), 64'd1);
        check("R5 pa", 64'(g_pa), 64'h1_2345_6567);
        check("R10 earlier fault kept", 64'(flt_addr), 64'h0123_4000);
    endtask

    task automatic t_invalid();
        run_xlate(32'h00AB_CDEF, 1'b0, 32'hFFFF_FF84, 3'd2, 32'h0010_0000, 0, 0);
        check("R7 invalid read faults", 64'(g_fault), 64'd1);
        check("R10 read status", 64'(flt_status), 64'hC086_0000);
        check("R10 overwrite addr", 64'(flt_addr), 64'h00AB_C000);
        check("R11 irq", 64'(g_irq), 64'd1);
        run_xlate(32'h0077_1234, 1'b1, 32'h0000_0005, 3'd0, 32'h0010_0000, 0, 0);
        check("R7 invalid write faults", 64'(g_fault), 64'd1);
        check("R10 write status", 64'(flt_status), 64'hC082_0000);
        check("R9 perm none", 64'(g_perm), 64'd0);
    endtask

    task automatic t_ranges();
        run_xlate(32'h8765_4321, 1'b0, 32'h0000_0106, 3'd7, 32'h0100_0000, 0, 0);
        check("R5 range7 pa", 64'(g_pa), 64'h0_0000_1321);
        run_xlate(32'hF9AB_C000, 1'b0, 32'h0000_0106, 3'd3, 32'h0000_0040, 0, 0);
        check("R6 range3 perm", 64'(g_perm), 64'd3);
    endtask

    task automatic t_stall_hold();
        run_xlate(32'hFE00_3FFF, 1'b1, 32'h8000_0006, 3'd1, 32'h0000_1000, 3, 4);
        check("R5 stall pa", 64'(g_pa), 64'h8_0000_0FFF);
        check("R1 no extra read after hold", 64'(mem_req_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_rw();
        t_write_ro();
        t_read_ro();
        t_invalid();
        t_ranges();
        t_stall_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule